// File: doc/BRIEF.md
# Synthesizer Divider Chain with M Range Flag

This block is the counter chain of a clock synthesizer, reduced to digital logic. Everything runs on one system clock, `clk_i`. Two tick strobes stand for the edges of the slow reference and the fast VCO-rate signal. A fixed prescaler counts reference ticks and emits a one-cycle pulse after every sixteenth tick. That pulse is the comparison reference.

A feedback counter counts VCO ticks and emits a one-cycle pulse after every 2·M ticks. A downstream phase comparator uses the two pulse streams, so the loop settles with the VCO rate equal to the reference × 2M / 16.

An output divider toggles a 50% duty clock at VCO-tick / 2 or VCO-tick / 4. The N code selects the ratio, and parallel mode forces /2. New M and N values take effect only at a period boundary of their own counter. A flag reports when the active M lies outside the lockable window of 125 to 350.

Top module: `synth_div_chain`

## Requirements
- R1: `ref_pulse_o` is high for exactly one cycle, in the cycle after every 16th `ref_tick_i` strobe counted from reset. It is low at all other times.
- R2: `fb_pulse_o` is high for exactly one cycle, in the cycle after every 2·M-th `vco_tick_i` strobe, where M is the active feedback value. The first period after reset uses M = 200.
- R3: `m_i` is sampled only on the tick that ends a feedback period, and it sets the length of the next period. A change of `m_i` in the middle of a period does not alter the position of the next pulse.
- R4: `m_range_err_o` is 1 exactly when the active M is below 125 or above 350. It changes only in the cycle in which `fb_pulse_o` is high.
- R5: `out_clk_o` toggles one cycle after a counted VCO tick. With N code 0 (`n_sel_i`=0) it toggles on every tick (divide by 2). With N code 1 it toggles on every second tick (divide by 4). High and low phases are equal.
- R6: While `par_mode_i` is 1, the output divider uses divide by 2 whatever the value of `n_sel_i`.
- R7: A new N selection is taken only on the tick that ends a high phase of `out_clk_o`. No high or low phase is ever shortened.
- R8: Reset clears all counters, drives all outputs low, and sets the active M to 200 and the output ratio to divide by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference edge strobe |
| vco_tick_i | input | 1 | VCO-rate edge strobe |
| m_i | input | 9 | Requested feedback value M |
| n_sel_i | input | 1 | Output ratio code: 0 = /2, 1 = /4 |
| par_mode_i | input | 1 | Parallel mode, forces /2 |
| ref_pulse_o | output | 1 | Reference pulse, one cycle |
| fb_pulse_o | output | 1 | Feedback pulse, one cycle |
| out_clk_o | output | 1 | Divided 50% duty output |
| m_range_err_o | output | 1 | Active M outside 125..350 |

## Verification
Both pulses and every `out_clk_o` toggle are due one cycle after the rising edge that samples the terminal tick. The range flag moves in that same cycle together with the feedback pulse, because it decodes the newly loaded M.

The bench model advances on each rising edge from the inputs, which are held stable since the previous falling edge. The model is compared with all four outputs at the following falling edge, so every result is checked in the cycle it is due.

Stimulus changes M and N in mid-period and uses steady, gapped and irregular tick patterns. It also places M on both sides of each window bound.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  typedef enum logic {NDIV2 = 1'b0, NDIV4 = 1'b1} ndiv_e;
endpackage

// File: rtl/sdc_ref_prescaler.sv
module sdc_ref_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt_q;
  logic          term;

  assign term = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tick_i && term;
      if (tick_i) cnt_q <= term ? '0 : cnt_q + 1'b1;
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  a_r1_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick_i));
endmodule

// File: rtl/sdc_fb_divider.sv
module sdc_fb_divider #(
  parameter int M_W   = 9,
  parameter int M_RST = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [M_W-1:0] m_i,
  output logic           pulse_o,
  output logic [M_W-1:0] m_act_o
);
  localparam int CW = M_W + 1;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   lim, nxt;
  logic          term;

  assign lim  = {1'b0, m_act_o, 1'b0};
  assign nxt  = {1'b0, cnt_q} + 1'b1;
  assign term = (nxt >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
      m_act_o <= M_W'(M_RST);
    end else begin
      pulse_o <= tick_i && term;
      if (tick_i) begin
        if (term) begin
          cnt_q   <= '0;
          m_act_o <= m_i;  // reload only at period boundary
        end else begin
          cnt_q <= nxt[CW-1:0];
        end
      end
    end
  end

  a_r3_m_held_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> $stable(m_act_o));
  a_r2_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick_i));
endmodule

// File: rtl/sdc_range_chk.sv
module sdc_range_chk #(
  parameter int M_W   = 9,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input  logic [M_W-1:0] m_i,
  output logic           err_o
);
  assign err_o = (m_i < M_W'(M_MIN)) || (m_i > M_W'(M_MAX));
endmodule

// File: rtl/sdc_out_divider.sv
module sdc_out_divider
  import synth_div_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  ndiv_e n_sel_i,
  output logic  out_o
);
  ndiv_e n_act_q;
  logic  cnt_q;
  logic  half_end;

  assign half_end = (n_act_q == NDIV4) ? cnt_q : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= 1'b0;
      out_o   <= 1'b0;
      n_act_q <= NDIV2;
    end else if (tick_i) begin
      if (half_end) begin
        cnt_q <= 1'b0;
        out_o <= !out_o;
        if (out_o) n_act_q <= n_sel_i;  // end of full period
      end else begin
        cnt_q <= 1'b1;
      end
    end
  end

  a_r5_toggle_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> $past(tick_i));
  a_r7_n_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_act_q) |-> $fell(out_o));
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int REF_DIV = 16,
  parameter int M_W     = 9,
  parameter int M_MIN   = 125,
  parameter int M_MAX   = 350,
  parameter int M_RST   = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_tick_i,
  input  logic           vco_tick_i,
  input  logic [M_W-1:0] m_i,
  input  logic           n_sel_i,
  input  logic           par_mode_i,
  output logic           ref_pulse_o,
  output logic           fb_pulse_o,
  output logic           out_clk_o,
  output logic           m_range_err_o
);
  logic [M_W-1:0] m_act;
  ndiv_e          n_code;

  assign n_code = par_mode_i ? NDIV2 : ndiv_e'(n_sel_i);

  sdc_ref_prescaler #(.DIV(REF_DIV)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick_i), .pulse_o(ref_pulse_o)
  );

  sdc_fb_divider #(.M_W(M_W), .M_RST(M_RST)) u_fb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(vco_tick_i), .m_i(m_i),
    .pulse_o(fb_pulse_o), .m_act_o(m_act)
  );

  sdc_range_chk #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_rng (
    .m_i(m_act), .err_o(m_range_err_o)
  );

  sdc_out_divider u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(vco_tick_i), .n_sel_i(n_code),
    .out_o(out_clk_o)
  );

  a_r4_flag_moves_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(m_range_err_o) |-> fb_pulse_o);
endmodule

// File: tb/sim_synth_div_chain.sv
module sim_synth_div_chain;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, vco_tick = 1'b0;
  logic [8:0] m_in = 9'd130;
  logic       n_sel = 1'b0, par = 1'b0;
  logic       ref_pulse, fb_pulse, out_clk, m_err;

  int  n_total = 0, n_fail = 0;
  int  tick_mode = 0;
  int  cyc = 0;
  string fb_tag = "R2", out_tag = "R5", rng_tag = "R4";

  // model state
  int rc, fc, ma, na, oc;
  bit e_ref, e_fb, e_out, e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_div_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .vco_tick_i(vco_tick),
    .m_i(m_in), .n_sel_i(n_sel), .par_mode_i(par),
    .ref_pulse_o(ref_pulse), .fb_pulse_o(fb_pulse), .out_clk_o(out_clk),
    .m_range_err_o(m_err)
  );

  task automatic chk(string tag, string what, bit act, bit exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc = 0; fc = 0; ma = 200; na = 0; oc = 0;
      e_ref = 0; e_fb = 0; e_out = 0; e_err = 0;
    end else begin
      e_ref = ref_tick && (rc == 15);
      if (ref_tick) rc = (rc + 1) % 16;
      e_fb = 0;
      if (vco_tick) begin
        if (fc + 1 >= 2 * ma) begin
          fc = 0; e_fb = 1; ma = m_in;
        end else fc++;
        if (oc + 1 >= (na ? 2 : 1)) begin
          oc = 0;
          if (e_out) na = par ? 0 : n_sel;
          e_out = !e_out;
        end else oc++;
      end
      e_err = (ma < 125) || (ma > 350);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1", "ref_pulse", ref_pulse, e_ref);
      chk(fb_tag, "fb_pulse", fb_pulse, e_fb);
      chk(rng_tag, "m_range_err", m_err, e_err);
      chk(out_tag, "out_clk", out_clk, e_out);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (tick_mode)
        0: begin ref_tick = 1'b1; vco_tick = 1'b1; end
        1: begin ref_tick = (cyc % 3 == 0); vco_tick = (cyc % 3 != 1); end
        default: begin ref_tick = 1'($urandom % 2); vco_tick = 1'($urandom % 2); end
      endcase
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_total++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    finish_run();
  end

  initial begin
    // R8: reset state
    #(CLK_PERIOD * 2);
    chk("R8", "ref_pulse reset", ref_pulse, 1'b0);
    chk("R8", "fb_pulse reset", fb_pulse, 1'b0);
    chk("R8", "out_clk reset", out_clk, 1'b0);
    chk("R8", "m_range_err reset (M=200)", m_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    run(600);                            // R1, R2: steady ticks, first period M=200
    fb_tag = "R3"; m_in = 9'd100; run(700);   // R3 mid-period change, R4 flag rises
    out_tag = "R5"; n_sel = 1'b1; run(303);   // R5 divide by 4
    out_tag = "R7"; n_sel = 1'b0; run(300);   // R7 switch inside a phase
    n_sel = 1'b1; run(5); n_sel = 1'b0; run(100);
    out_tag = "R6"; par = 1'b1; n_sel = 1'b1; run(300);  // R6 forced /2
    par = 1'b0; out_tag = "R5";
    tick_mode = 1; rng_tag = "R4";
    m_in = 9'd351; run(1500);            // R4 just above window
    m_in = 9'd350; run(2200);            // R4 upper bound inside
    tick_mode = 2;
    m_in = 9'd125; run(1500);            // R4 lower bound inside
    m_in = 9'd124; run(1200);            // R4 just below window
    fb_tag = "R2"; m_in = 9'd2; run(200);
    finish_run();
  end
endmodule